// File: doc/BRIEF.md
# Digital Soft-Start Sequencer with Short-Circuit Latch

This block sequences the start-up of a synchronous step-down converter. A counter advanced once per switching cycle drives a digital reference code that climbs linearly from zero to its full-scale value. The full-scale value stands for the 0.8 V regulation target. A downstream converter turns the code into the error-amplifier reference. When the counter saturates, the reference holds at full scale and a done flag is raised.

The block also guards the output against a short. A digitized feedback code is compared with half of the present reference code. The comparison stays blanked for the first half of the ramp and is armed from then on. An undervoltage that lasts for a programmable number of consecutive cycle ticks sets a fault latch, which withdraws the permit for both power-stage drives. Dropping the synchronized enable clears the ramp and withdraws the drive permit. Only a power-on reset clears the fault latch.

Top module: `softstart_guard`

## Requirements
- R1: While `por_n` is low, `ref_code`, `drive_ok`, `fault` and `ss_done` are all 0.
- R2: While enabled and not faulted, each cycle tick advances the ramp count by one, up to RAMP_CYCLES. `ref_code` equals count*FULL_CODE/RAMP_CYCLES, rounded down. Ticks have no effect while enable is low.
- R3: The undervoltage check is ignored while the ramp count is below RAMP_CYCLES/2, and it is active once the count is at or above that value.
- R4: Undervoltage means `fb_code` is strictly less than `ref_code` shifted right by one bit. A feedback code equal to that threshold is not an undervoltage.
- R5: `en_cmp` passes through SYNC_STAGES flip-flops. While the synchronized enable is low, the ramp count is held at 0 and `drive_ok` is 0. When it rises again, the ramp restarts from zero.
- R6: The tick that completes the undervoltage filter sets `fault` at that clock edge. From then on, `drive_ok` is 0 and `fault` stays 1. From the next clock on, `ref_code` is 0.
- R7: When the ramp count reaches RAMP_CYCLES, `ss_done` is 1 and `ref_code` equals FULL_CODE. Further ticks leave both unchanged.
- R8: Toggling `en_cmp` neither clears `fault` nor restarts the ramp. Only `por_n` low clears `fault`.
- R9: The fault latches only after FILT_LEN consecutive ticks that are armed and in undervoltage. A tick without undervoltage restarts the filter count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Supply power-on reset, active low, asynchronous |
| cyc_tick | input | 1 | One-clock pulse per switching cycle |
| en_cmp | input | 1 | Enable comparator output, asynchronous |
| fb_code | input | REF_W | Digitized feedback voltage |
| ref_code | output | REF_W | Soft-start reference code |
| drive_ok | output | 1 | Permit for both power-stage drives |
| fault | output | 1 | Short-circuit latch state |
| ss_done | output | 1 | Ramp has reached full scale |

## Verification
The bench builds the block with RAMP_CYCLES=64, FILT_LEN=4, FULL_CODE=800 and two synchronizer stages. The short ramp makes it cheap to reach the blanking edge at count 32, full-scale saturation and repeated restarts within one run. A filter of four ticks lets the bench interrupt an undervoltage streak at three ticks and then complete it at four. A full scale of 800 puts the threshold at 400, which gives an exact boundary at feedback codes 399 and 400.

// File: rtl/ssg_pkg.sv
package ssg_pkg;
   // coarse phase of the start-up ramp, decoded from the ramp count
   typedef enum logic [1:0] {
      PH_HOLD  = 2'd0,
      PH_BLANK = 2'd1,
      PH_ARMED = 2'd2,
      PH_FULL  = 2'd3
   } ssg_phase_e;
endpackage

// File: rtl/ssg_sync.sv
module ssg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_sync = d_async;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2+1-1:0], d_async} ;
         end
         assign q_sync = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ssg_ramp.sv
module ssg_ramp
   import ssg_pkg::*;
#(
   parameter int RAMP_CYCLES = 1024,
   parameter int REF_W       = 10,
   parameter int FULL_CODE   = 800,
   localparam int LOG2R      = $clog2(RAMP_CYCLES),
   localparam int CNT_W      = LOG2R + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   output logic [CNT_W-1:0] count_q,
   output logic [REF_W-1:0] ref_code,
   output ssg_phase_e       phase
);
   localparam int PROD_W = LOG2R + REF_W;
   localparam int HALF   = RAMP_CYCLES / 2;

   logic             at_full;
   logic [PROD_W-1:0] prod;

   assign at_full = (count_q == CNT_W'(RAMP_CYCLES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              count_q <= '0;
      else if (!run)           count_q <= '0;
      else if (tick && !at_full) count_q <= count_q + CNT_W'(1);
   end

   always_comb begin
      prod     = PROD_W'(count_q) * PROD_W'(FULL_CODE);
      ref_code = REF_W'(prod >> LOG2R);
   end

   always_comb begin
      if (at_full)                          phase = PH_FULL;
      else if (count_q >= CNT_W'(HALF))     phase = PH_ARMED;
      else if (count_q != '0)               phase = PH_BLANK;
      else                                  phase = PH_HOLD;
   end
endmodule

// File: rtl/ssg_uvfilt.sv
module ssg_uvfilt #(
   parameter int FILT_LEN = 8,
   parameter int REF_W    = 10,
   localparam int FW      = $clog2(FILT_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clear,
   input  logic             armed,
   input  logic [REF_W-1:0] fb_code,
   input  logic [REF_W-1:0] ref_code,
   output logic             trip
);
   logic [REF_W-1:0] thresh;
   logic             low_fb;
   logic             hit;
   logic [FW-1:0]    run_q;

   assign thresh = ref_code >> 1;
   assign low_fb = (fb_code < thresh);
   assign hit    = tick && armed && low_fb;
   assign trip   = hit && (run_q == FW'(FILT_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    run_q <= '0;
      else if (clear)                run_q <= '0;
      else if (tick) begin
         if (!hit)                   run_q <= '0;
         else if (run_q != FW'(FILT_LEN)) run_q <= run_q + FW'(1);
      end
   end
endmodule

// File: rtl/softstart_guard.sv
module softstart_guard
   import ssg_pkg::*;
#(
   parameter int RAMP_CYCLES = 1024,
   parameter int REF_W       = 10,
   parameter int FULL_CODE   = 800,
   parameter int FILT_LEN    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             cyc_tick,
   input  logic             en_cmp,
   input  logic [REF_W-1:0] fb_code,
   output logic [REF_W-1:0] ref_code,
   output logic             drive_ok,
   output logic             fault,
   output logic             ss_done
);
   localparam int CNT_W = $clog2(RAMP_CYCLES) + 1;

   generate
      if ((RAMP_CYCLES < 2) || ((RAMP_CYCLES & (RAMP_CYCLES - 1)) != 0)) begin : g_bad_ramp
         $error("RAMP_CYCLES must be a power of two of at least 2");
      end
      if ((FULL_CODE < 1) || (FULL_CODE > (2**REF_W) - 1)) begin : g_bad_full
         $error("FULL_CODE must fit in REF_W bits");
      end
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("FILT_LEN must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic             en_s;
   logic             fault_q;
   logic             run;
   logic             trip;
   logic             armed;
   logic [CNT_W-1:0] count_q;
   ssg_phase_e       phase;

   ssg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (por_n),
      .d_async (en_cmp),
      .q_sync  (en_s)
   );

   assign run   = en_s && !fault_q;
   assign armed = (phase == PH_ARMED) || (phase == PH_FULL);

   ssg_ramp #(
      .RAMP_CYCLES (RAMP_CYCLES),
      .REF_W       (REF_W),
      .FULL_CODE   (FULL_CODE)
   ) u_ramp (
      .clk      (clk),
      .rst_n    (por_n),
      .tick     (cyc_tick),
      .run      (run),
      .count_q  (count_q),
      .ref_code (ref_code),
      .phase    (phase)
   );

   ssg_uvfilt #(
      .FILT_LEN (FILT_LEN),
      .REF_W    (REF_W)
   ) u_filt (
      .clk      (clk),
      .rst_n    (por_n),
      .tick     (cyc_tick),
      .clear    (!run),
      .armed    (armed),
      .fb_code  (fb_code),
      .ref_code (ref_code),
      .trip     (trip)
   );

   // only the supply reset releases the latch
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)    fault_q <= 1'b0;
      else if (trip) fault_q <= 1'b1;
   end

   assign fault    = fault_q;
   assign drive_ok = run;
   assign ss_done  = (phase == PH_FULL);
endmodule

// File: rtl/softstart_guard_chk.sv
module softstart_guard_chk #(
   parameter int RAMP_CYCLES = 1024,
   parameter int REF_W       = 10,
   parameter int FULL_CODE   = 800,
   localparam int CNT_W      = $clog2(RAMP_CYCLES) + 1
) (
   input logic             clk,
   input logic             por_n,
   input logic [REF_W-1:0] ref_code,
   input logic             drive_ok,
   input logic             fault,
   input logic             ss_done,
   input logic [CNT_W-1:0] count_q
);
   // R6: latch never releases without power-on reset
   a_r6_fault_sticky: assert property (@(posedge clk) disable iff (!por_n)
      fault |=> fault);

   // R6: no drive permit while latched
   a_r6_no_drive: assert property (@(posedge clk) disable iff (!por_n)
      fault |-> !drive_ok);

   // R6: reference collapses one clock after the latch is set
   a_r6_ref_cleared: assert property (@(posedge clk) disable iff (!por_n)
      fault |=> (ref_code == '0));

   // R3: a latch can only be set from an armed ramp count
   a_r3_armed_only: assert property (@(posedge clk) disable iff (!por_n)
      $rose(fault) |-> ($past(count_q) >= CNT_W'(RAMP_CYCLES / 2)));

   // R7: done implies full-scale reference
   a_r7_done_full: assert property (@(posedge clk) disable iff (!por_n)
      ss_done |-> (ref_code == REF_W'(FULL_CODE)));

   // R2: reference never falls while the drive stays permitted
   a_r2_monotonic: assert property (@(posedge clk) disable iff (!por_n)
      (drive_ok && $past(drive_ok)) |-> (ref_code >= $past(ref_code)));
endmodule

bind softstart_guard softstart_guard_chk #(
   .RAMP_CYCLES (RAMP_CYCLES),
   .REF_W       (REF_W),
   .FULL_CODE   (FULL_CODE)
) i_chk (
   .clk      (clk),
   .por_n    (por_n),
   .ref_code (ref_code),
   .drive_ok (drive_ok),
   .fault    (fault),
   .ss_done  (ss_done),
   .count_q  (count_q)
);

// File: tb/test_softstart_guard.sv
`timescale 1ns/1ps
module test_softstart_guard;
   localparam int RAMP = 64;
   localparam int RW   = 10;
   localparam int FULL = 800;
   localparam int FILT = 4;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          cyc_tick = 1'b0;
   logic          en_cmp = 1'b0;
   logic [RW-1:0] fb_code = RW'(FULL);
   logic [RW-1:0] ref_code;
   logic          drive_ok, fault, ss_done;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   softstart_guard #(
      .RAMP_CYCLES (RAMP), .REF_W (RW), .FULL_CODE (FULL),
      .FILT_LEN (FILT), .SYNC_STAGES (2)
   ) i_softstart_guard (
      .clk (clk), .por_n (por_n), .cyc_tick (cyc_tick), .en_cmp (en_cmp),
      .fb_code (fb_code), .ref_code (ref_code), .drive_ok (drive_ok),
      .fault (fault), .ss_done (ss_done)
   );

   // behavioural reference model
   int m_s0, m_s1, m_cnt, m_filt, m_fault;
   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_s0 = 0; m_s1 = 0; m_cnt = 0; m_filt = 0; m_fault = 0;
      end else begin
         int r, low, arm;
         r   = m_cnt * FULL / RAMP;
         low = (int'(fb_code) < r / 2);
         arm = (m_cnt >= RAMP / 2);
         if (m_s1 == 0 || m_fault != 0) begin
            m_cnt = 0; m_filt = 0;
         end else if (cyc_tick) begin
            if (low && arm) begin
               if (m_filt == FILT - 1) m_fault = 1;
               if (m_filt < FILT) m_filt++;
            end else m_filt = 0;
            if (m_cnt < RAMP) m_cnt++;
         end
         m_s1 = m_s0;
         m_s0 = int'(en_cmp);
      end
   end

   task automatic check_val(string tag, int got, int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
      end
   endtask

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (!finished) begin
         check_val("R2 ref_code vs model", int'(ref_code), m_cnt * FULL / RAMP);
         check_val("R5 drive_ok vs model", int'(drive_ok), (m_s1 != 0 && m_fault == 0) ? 1 : 0);
         check_val("R6 fault vs model", int'(fault), m_fault);
         check_val("R7 ss_done vs model", int'(ss_done), (m_cnt == RAMP) ? 1 : 0);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         finished = 1'b1;
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic clocks(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic ticks(int n);
      repeat (n) begin
         @(negedge clk); #1 cyc_tick = 1'b1;
         @(negedge clk); #1 cyc_tick = 1'b0;
         @(negedge clk); #1;
      end
   endtask

   initial begin
      clocks(5);
      check_val("R1 reset ref_code", int'(ref_code), 0);
      check_val("R1 reset drive_ok", int'(drive_ok), 0);
      check_val("R1 reset fault", int'(fault), 0);
      check_val("R1 reset ss_done", int'(ss_done), 0);
      por_n = 1'b1;
      ticks(3);
      check_val("R2 ticks ignored while disabled", int'(ref_code), 0);

      en_cmp = 1'b1;
      clocks(3);
      check_val("R5 drive after sync", int'(drive_ok), 1);
      ticks(10);
      check_val("R2 ref after 10 ticks", int'(ref_code), 10 * FULL / RAMP);
      ticks(54);
      check_val("R7 done at full", int'(ss_done), 1);
      check_val("R7 ref at full", int'(ref_code), FULL);
      ticks(5);
      check_val("R7 ref holds", int'(ref_code), FULL);

      fb_code = RW'(400);
      ticks(10);
      check_val("R4 fb equal to threshold no fault", int'(fault), 0);
      fb_code = RW'(399);
      ticks(3);
      fb_code = RW'(400);
      ticks(1);
      fb_code = RW'(399);
      ticks(3);
      check_val("R9 interrupted streak no fault", int'(fault), 0);
      ticks(1);
      check_val("R9 fourth tick latches fault", int'(fault), 1);
      check_val("R6 drive off on fault", int'(drive_ok), 0);
      check_val("R6 ref cleared on fault", int'(ref_code), 0);

      en_cmp = 1'b0;
      clocks(5);
      en_cmp = 1'b1;
      clocks(5);
      ticks(5);
      check_val("R8 enable toggle keeps fault", int'(fault), 1);
      check_val("R8 no ramp restart while faulted", int'(ref_code), 0);

      por_n = 1'b0;
      clocks(2);
      check_val("R8 por clears fault", int'(fault), 0);
      por_n = 1'b1;
      fb_code = '0;
      clocks(3);
      ticks(31);
      check_val("R3 blanked below half", int'(fault), 0);
      ticks(10);
      check_val("R3 armed short latches", int'(fault), 1);

      por_n = 1'b0;
      clocks(2);
      por_n = 1'b1;
      fb_code = RW'(FULL);
      clocks(3);
      ticks(20);
      en_cmp = 1'b0;
      clocks(3);
      check_val("R5 drive off when enable low", int'(drive_ok), 0);
      check_val("R5 ramp cleared when enable low", int'(ref_code), 0);
      en_cmp = 1'b1;
      clocks(3);
      ticks(4);
      check_val("R5 ramp restarts from zero", int'(ref_code), 4 * FULL / RAMP);

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule